// File: doc/BRIEF.md
# Baud Rate Divisor Unit

This unit produces the timing strobes for a serial receiver and transmitter. A free-running down-counter divides the system clock by a 16-bit divisor and emits a one-cycle sample strobe at the divided rate. A second counter groups these strobes into bit periods of either 16 or 4 samples. The oversampling ratio is set by a small rate-step register. Low rates use 16 samples per bit. High rates use 4 samples per bit, so a given clock can reach a bit rate four times higher.

Software programs the divisor through a simple write/read strobe bus. It first sets the access bit in the line register, then writes the low byte and the high byte, then clears the access bit again. While the access bit is clear, the two divisor addresses are passed to an external data-register port. A force bit pins the period at its maximum while the baud rate is being detected, so the receiver cannot lock onto a wrong rate. An optional combinational helper turns a requested baud value into a divisor, rounded to nearest, together with the matching rate-step code.

Top module: `baud_divisor_unit`

## Requirements
- R1: After reset the line register, the rate-step register and the force bit are 0, and the divisor reads back as low byte 0x01 and high byte 0x00. The sample strobe is then high on every cycle.
- R2: While bit 7 of the line register (address 3) is 1, a write to address 0 loads the divisor low byte and a write to address 1 loads the high byte. Reads from these addresses return the same bytes.
- R3: While bit 7 of the line register is 0, a write or read at address 0 or 1 raises extWe or extRe for that cycle, with extSel equal to address bit 0 and extWdata equal to wdata. A read returns extRdata, and the divisor does not change.
- R4: The sample strobe is high for one cycle in every D clock cycles, where D is the committed divisor.
- R5: The divisor is committed only by the high-byte write, which combines it with the stored low byte. A low-byte write on its own leaves the period unchanged. The strobe already counting down still fires on the old period, and the new period applies from that strobe onward.
- R6: A committed divisor of 0 behaves as 1, so the sample strobe is high on every cycle.
- R7: Rate-step register (address 2, bits 1:0) value 2 gives 4 samples per bit; every other value gives 16. The bit strobe is high only together with a sample strobe, once every 4 or 16 sample strobes.
- R8: Bit 0 of the force register (address 4) set to 1 makes the sample period 65535 cycles whatever the divisor. The stored divisor keeps its value.
- R9: For a requested baud at or below 115200, the helper outputs clock/(16*baud) rounded to nearest, with rate-step code 0.
- R10: For a requested baud above 115200, the helper outputs clock/(4*baud) rounded to nearest, with rate-step code 2. A remainder of exactly half the denominator rounds up.
- R11: The line register reads back all 8 bits. Addresses 5 to 7 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle rdEn is high |
| extWe | output | 1 | Write strobe to the data registers |
| extRe | output | 1 | Read strobe to the data registers |
| extSel | output | 1 | Data register select (address bit 0) |
| extWdata | output | 8 | Write data to the data registers |
| extRdata | input | 8 | Read data from the data registers |
| reqBaud | input | 24 | Requested baud for the divisor helper |
| calcDiv | output | 16 | Rounded divisor from the helper |
| calcStep | output | 2 | Rate-step code from the helper |
| sampleTick | output | 1 | Sample strobe at the divided rate |
| bitTick | output | 1 | End-of-bit strobe |

## Verification
The bound checker watches every cycle for the following. The countdown must step down by one between strobes and reload from the committed divisor, or from 0xFFFF while forced. A zero divisor must strobe back to back. The sample count must advance by one on each non-final strobe. The committed divisor must change only on a high-byte write with the access bit set. Only the bench scenarios can show the effects that span many cycles or involve the bus. These are the measured sample and bit periods across divisor and ratio pairs, and the old period finishing before a new divisor applies. They also cover the routing of the divisor addresses to the external port when the access bit is clear, and the helper's rounding at the half-way remainder.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ADR_LOW  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_HIGH = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STEP = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_AUTO = 3'd4;
  localparam int LATCH_BIT = 7;
  localparam logic [1:0] STEP_FAST = 2'd2;
  localparam int OVS_SLOW = 16;
  localparam int OVS_FAST = 4;
  localparam int OVS_W = $clog2(OVS_SLOW);

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic loadStep;
    logic loadAuto;
    logic [BYTE_W-1:0] wbyte;
  } divStrobe_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] extRdata,
  input  logic [BYTE_W-1:0] divLowQ,
  input  logic [BYTE_W-1:0] divHighQ,
  input  logic [1:0]        stepQ,
  input  logic              autoQ,
  output divStrobe_t        strobe,
  output logic [BYTE_W-1:0] rdData,
  output logic              extWe,
  output logic              extRe,
  output logic              extSel,
  output logic [BYTE_W-1:0] extWdata
);
  logic [BYTE_W-1:0] lineReg;
  logic latchOpen;
  logic dataSpace;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineReg <= '0;
    else if (wrEn && addr == ADR_LINE) lineReg <= wdata;
  end

  assign latchOpen = lineReg[LATCH_BIT];
  assign dataSpace = (addr == ADR_LOW) || (addr == ADR_HIGH);

  always_comb begin
    strobe          = '0;
    strobe.wbyte    = wdata;
    strobe.loadLow  = wrEn && latchOpen && (addr == ADR_LOW);
    strobe.loadHigh = wrEn && latchOpen && (addr == ADR_HIGH);
    strobe.loadStep = wrEn && (addr == ADR_STEP);
    strobe.loadAuto = wrEn && (addr == ADR_AUTO);
  end

  assign extWe    = wrEn && !latchOpen && dataSpace;
  assign extRe    = rdEn && !latchOpen && dataSpace;
  assign extSel   = addr[0];
  assign extWdata = wdata;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADR_LOW:  rdData = latchOpen ? divLowQ : extRdata;
        ADR_HIGH: rdData = latchOpen ? divHighQ : extRdata;
        ADR_STEP: rdData = {{(BYTE_W-2){1'b0}}, stepQ};
        ADR_LINE: rdData = lineReg;
        ADR_AUTO: rdData = {{(BYTE_W-1){1'b0}}, autoQ};
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 16'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  output logic [BYTE_W-1:0] divLowQ,
  output logic [BYTE_W-1:0] divHighQ,
  output logic [1:0]        stepQ,
  output logic              autoQ,
  output logic              sampleTick,
  output logic              bitTick
);
  localparam logic [OVS_W-1:0] LAST_SLOW = OVS_W'(OVS_SLOW - 1);
  localparam logic [OVS_W-1:0] LAST_FAST = OVS_W'(OVS_FAST - 1);

  logic [BYTE_W-1:0] stageLow;
  logic [DIV_W-1:0]  divReg;
  logic [1:0]        stepReg;
  logic              autoReg;
  logic [DIV_W-1:0]  cnt;
  logic [OVS_W-1:0]  sampleCnt;
  logic [DIV_W-1:0]  reloadVal;
  logic [OVS_W-1:0]  lastSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageLow <= RESET_DIV[BYTE_W-1:0];
      divReg   <= RESET_DIV;
      stepReg  <= '0;
      autoReg  <= 1'b0;
    end else begin
      if (strobe.loadLow)  stageLow <= strobe.wbyte;
      if (strobe.loadHigh) divReg   <= {strobe.wbyte, stageLow};
      if (strobe.loadStep) stepReg  <= strobe.wbyte[1:0];
      if (strobe.loadAuto) autoReg  <= strobe.wbyte[0];
    end
  end

  always_comb begin
    if (autoReg)           reloadVal = '1;
    else if (divReg == '0) reloadVal = DIV_W'(1);
    else                   reloadVal = divReg;
  end

  assign sampleTick = (cnt == '0);
  assign lastSample = (stepReg == STEP_FAST) ? LAST_FAST : LAST_SLOW;
  assign bitTick    = sampleTick && (sampleCnt >= lastSample);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      sampleCnt <= '0;
    end else begin
      if (sampleTick) cnt <= reloadVal - DIV_W'(1);
      else            cnt <= cnt - DIV_W'(1);
      if (bitTick)         sampleCnt <= '0;
      else if (sampleTick) sampleCnt <= sampleCnt + OVS_W'(1);
    end
  end

  assign divLowQ  = stageLow;
  assign divHighQ = divReg[DIV_W-1:BYTE_W];
  assign stepQ    = stepReg;
  assign autoQ    = autoReg;
endmodule

// File: rtl/baud_calc.sv
module baud_calc
  import baud_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 26_000_000,
  parameter int          BAUD_W     = 24,
  parameter int unsigned SPLIT_BAUD = 115_200
) (
  input  logic [BAUD_W-1:0] reqBaud,
  output logic [DIV_W-1:0]  calcDiv,
  output logic [1:0]        calcStep
);
  localparam int WIDE_W = BAUD_W + 16;
  localparam logic [WIDE_W-1:0] CLK_V = WIDE_W'(CLK_HZ);

  logic fast;
  logic [WIDE_W-1:0] den, quo, rem;

  always_comb begin
    fast = reqBaud > BAUD_W'(SPLIT_BAUD);
    den  = fast ? (WIDE_W'(reqBaud) << 2) : (WIDE_W'(reqBaud) << 4);
    if (den == '0) begin
      quo = '0;
      rem = '0;
    end else begin
      quo = CLK_V / den;
      rem = CLK_V % den;
      if ((rem << 1) >= den) quo = quo + WIDE_W'(1);
    end
    calcDiv  = (quo > WIDE_W'(16'hFFFF)) ? 16'hFFFF : quo[DIV_W-1:0];
    calcStep = fast ? STEP_FAST : 2'd0;
  end
endmodule

// File: rtl/baud_divisor_unit.sv
module baud_divisor_unit
  import baud_pkg::*;
#(
  parameter int unsigned      CLK_HZ     = 26_000_000,
  parameter int               BAUD_W     = 24,
  parameter int unsigned      SPLIT_BAUD = 115_200,
  parameter logic [DIV_W-1:0] RESET_DIV  = 16'd1,
  parameter bit               CALC_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdData,
  output logic              extWe,
  output logic              extRe,
  output logic              extSel,
  output logic [BYTE_W-1:0] extWdata,
  input  logic [BYTE_W-1:0] extRdata,
  input  logic [BAUD_W-1:0] reqBaud,
  output logic [DIV_W-1:0]  calcDiv,
  output logic [1:0]        calcStep,
  output logic              sampleTick,
  output logic              bitTick
);
  divStrobe_t        strobe;
  logic [BYTE_W-1:0] divLowQ, divHighQ;
  logic [1:0]        stepQ;
  logic              autoQ;

  baud_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .extRdata(extRdata), .divLowQ(divLowQ),
    .divHighQ(divHighQ), .stepQ(stepQ), .autoQ(autoQ), .strobe(strobe),
    .rdData(rdData), .extWe(extWe), .extRe(extRe), .extSel(extSel),
    .extWdata(extWdata)
  );

  baud_dp #(.RESET_DIV(RESET_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divLowQ(divLowQ),
    .divHighQ(divHighQ), .stepQ(stepQ), .autoQ(autoQ),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  generate
    if (CALC_EN) begin : gCalc
      baud_calc #(.CLK_HZ(CLK_HZ), .BAUD_W(BAUD_W), .SPLIT_BAUD(SPLIT_BAUD)) uCalc (
        .reqBaud(reqBaud), .calcDiv(calcDiv), .calcStep(calcStep)
      );
    end else begin : gNoCalc
      logic unusedBaud;
      assign unusedBaud = ^reqBaud;
      assign calcDiv  = '0;
      assign calcStep = '0;
    end
  endgenerate
endmodule

// File: rtl/baud_divisor_chk.sv
module baud_divisor_chk
  import baud_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] lineReg,
  input logic              sampleTick,
  input logic              bitTick,
  input logic              autoQ,
  input logic [DIV_W-1:0]  divReg,
  input logic [DIV_W-1:0]  cnt,
  input logic [OVS_W-1:0]  sampleCnt
);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick && !autoQ && divReg != '0 |=> cnt == $past(divReg) - 16'd1);

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> cnt == $past(cnt) - 16'd1);

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADR_HIGH && lineReg[LATCH_BIT]) |=> $stable(divReg));

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick && !autoQ && divReg == '0 |=> sampleTick);

  // R7
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  // R7
  sample_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick && !bitTick |=> sampleCnt == $past(sampleCnt) + 4'd1);

  // R8
  force_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick && autoQ |=> cnt == 16'hFFFE);
endmodule

bind baud_divisor_unit baud_divisor_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .lineReg(uCtrl.lineReg), .sampleTick(sampleTick), .bitTick(bitTick),
  .autoQ(autoQ), .divReg(uDp.divReg), .cnt(uDp.cnt), .sampleCnt(uDp.sampleCnt)
);

// File: tb/sim_baud_divisor_unit.sv
`timescale 1ns/1ps
module sim_baud_divisor_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, extRdata = '0;
  logic [23:0] reqBaud = '0;
  logic [7:0] rdData, extWdata;
  logic extWe, extRe, extSel, sampleTick, bitTick;
  logic [15:0] calcDiv;
  logic [1:0] calcStep;

  int nChecks = 0;
  int nFail = 0;
  longint cyc = 0;
  bit done = 1'b0;

  baud_divisor_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdData(rdData), .extWe(extWe), .extRe(extRe),
    .extSel(extSel), .extWdata(extWdata), .extRdata(extRdata),
    .reqBaud(reqBaud), .calcDiv(calcDiv), .calcStep(calcStep),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int NV = 6;
  localparam int V_DIV  [NV] = '{5, 3, 0, 7, 2, 258};
  localparam int V_STEP [NV] = '{0, 2, 0, 1, 3, 2};
  localparam int V_SPER [NV] = '{5, 3, 1, 7, 2, 258};
  localparam int V_BPER [NV] = '{80, 12, 16, 112, 32, 1032};

  localparam int NC = 7;
  localparam int C_BAUD [NC] = '{9600, 19200, 115200, 115201, 230400, 921600, 1000000};
  localparam int C_DIV  [NC] = '{169, 85, 14, 56, 28, 7, 7};
  localparam int C_STEP [NC] = '{0, 0, 0, 2, 2, 2, 2};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setDiv(input int dv);
    wr(3'd3, 8'h80);
    wr(3'd0, dv[7:0]);
    wr(3'd1, dv[15:8]);
    wr(3'd3, 8'h00);
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!sampleTick);
  endtask

  task automatic waitBit();
    do @(negedge clk); while (!bitTick);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 180000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=180000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    longint t0, t1, t2;
    int hits;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values and strobe on every cycle
    rd(3'd2, d); check("R1 step", d, 0);
    rd(3'd3, d); check("R1 line", d, 0);
    rd(3'd4, d); check("R1 force", d, 0);
    wr(3'd3, 8'h80);
    rd(3'd0, d); check("R1 low", d, 8'h01);
    rd(3'd1, d); check("R1 high", d, 8'h00);
    wr(3'd3, 8'h00);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      if (sampleTick) hits++;
      @(negedge clk);
    end
    check("R1 tick each cycle", hits, 4);

    // R2: divisor bytes via access bit
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, d); check("R2 low", d, 8'h34);
    rd(3'd1, d); check("R2 high", d, 8'h12);
    wr(3'd3, 8'h00);

    // R3: access bit clear routes to data port
    setDiv(6);
    wrEn = 1'b1; addr = 3'd0; wdata = 8'hAA;
    #1;
    check("R3 extWe", extWe, 1);
    check("R3 extSel", extSel, 0);
    check("R3 extWdata", extWdata, 8'hAA);
    @(negedge clk); wrEn = 1'b0;
    wr(3'd1, 8'h55);
    extRdata = 8'h5C;
    rdEn = 1'b1; addr = 3'd1;
    #1;
    check("R3 extRe", extRe, 1);
    check("R3 extSel read", extSel, 1);
    check("R3 read data", rdData, 8'h5C);
    @(negedge clk); rdEn = 1'b0;
    wr(3'd3, 8'h80);
    rd(3'd0, d); check("R3 low unchanged", d, 6);
    rd(3'd1, d); check("R3 high unchanged", d, 0);
    wr(3'd3, 8'h00);
    waitTick(); waitTick(); t0 = cyc; waitTick();
    check("R3 period unchanged", cyc - t0, 6);

    // R5: low byte alone does not commit
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h00);
    waitTick(); waitTick(); t0 = cyc; waitTick();
    check("R5 low only", cyc - t0, 6);

    // R5: old countdown finishes before new divisor
    setDiv(10);
    waitTick(); waitTick();
    t0 = cyc;
    setDiv(3);
    waitTick(); t1 = cyc;
    waitTick(); t2 = cyc;
    check("R5 old period", t1 - t0, 10);
    check("R5 new period", t2 - t1, 3);

    // R4 R6 R7: vector walk
    for (int i = 0; i < NV; i++) begin
      setDiv(V_DIV[i]);
      wr(3'd2, V_STEP[i][7:0]);
      waitTick(); waitTick();
      t0 = cyc; waitTick();
      check(V_DIV[i] == 0 ? "R6 zero divisor" : "R4 sample period", cyc - t0, V_SPER[i]);
      waitBit(); t0 = cyc; waitBit();
      check("R7 bit period", cyc - t0, V_BPER[i]);
    end

    // R11: line readback, unused addresses
    wr(3'd3, 8'h1B);
    rd(3'd3, d); check("R11 line", d, 8'h1B);
    wr(3'd5, 8'hFF);
    rd(3'd5, d); check("R11 addr5", d, 0);
    rd(3'd7, d); check("R11 addr7", d, 0);
    wr(3'd3, 8'h00);

    // R9 R10: divisor helper
    for (int i = 0; i < NC; i++) begin
      reqBaud = C_BAUD[i][23:0];
      #1;
      check(C_BAUD[i] > 115200 ? "R10 div" : "R9 div", calcDiv, C_DIV[i]);
      check(C_BAUD[i] > 115200 ? "R10 step" : "R9 step", calcStep, C_STEP[i]);
    end
    @(negedge clk);

    // R8: forced maximum period
    setDiv(3);
    waitTick(); waitTick();
    wr(3'd4, 8'h01);
    waitTick(); t0 = cyc; waitTick();
    check("R8 forced period", cyc - t0, 65535);
    wr(3'd3, 8'h80);
    rd(3'd0, d); check("R8 low kept", d, 3);
    rd(3'd1, d); check("R8 high kept", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule